// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block is the bus interface of a 16-bit processor core working without an external bus controller. A requester presents one transfer at a time: read or write, a 20-bit address, a memory or I/O select, an upper-byte enable, write data, a two-bit segment code and the current interrupt-enable flag. The sequencer runs the transfer as a fixed series of clock states on a shared pin set. In the first state the low 16 address bits go out on the shared data pins and the top four address bits go out on the address/status pins, with the latch strobe high. In the following states the shared pins carry data, and the top pins carry status.

A slow target can stretch a transfer by holding the ready input low. Each low sample adds one wait state between the second and third states. A DMA master can take the bus by raising the hold input. At the next transfer boundary the sequencer grants the bus. It then stops driving every bus pin except the latch strobe. When the transfer ends, read data and a one-cycle done pulse go back to the requester. Pin tri-state is shown as output enables (`ctl_oe`, `ad_oe`), so the pads can sit outside the block.

Top module: `mbus_cycle_seq`

## Requirements
- R1: A synchronous active-high reset returns the unit to idle on the next edge. In idle, `rd_n` and `wr_n` are 1, `ale`, `hlda` and `done` are 0, and `ctl_oe` is 1. This holds even when reset arrives in the middle of a transfer.
- R2: A request accepted on a clock edge (`req_valid` high while `req_ready` is high) makes the next cycle the address state. In that state `ale` is 1, `ad_oe` is 1, `ad_o` carries address bits 15..0 and `as_o` carries address bits 19..16. `ale` is 1 for that single cycle only, and no strobe is low while `ale` is 1.
- R3: In every state of a transfer after the address state, `as_o` carries status. Bit 3 is 0, bit 2 equals the interrupt-enable flag given with the request, and bits 1..0 equal the segment code.
- R4: `bhe_n` is the inverse of `req_hi_en` during the address state and is 1 in all later states of the transfer.
- R5: For a read, `rd_n` is 0 from the second state through the third state, including any wait states. `ad_oe` is 0 after the address state. `rdata` holds the value on `ad_i` at the clock edge that ends the third state, and it stays valid while `done` is 1.
- R6: For a write, `wr_n` is 0 from the second state through the third state, including any wait states. `ad_oe` stays 1 through the fourth state and `ad_o` carries the write data. `rd_n` and `wr_n` are never 0 together.
- R7: During a transfer, `mio` equals the request's memory select (1 selects memory, 0 selects I/O). `dtr` is 1 for a write and 0 for a read.
- R8: If `ready` is 0 at the edge that ends the second state, or at the edge that ends a wait state, one more wait state follows. Each wait state lasts one cycle and keeps the strobe low. With no wait, the third state follows the second.
- R9: When `hold` is 1 in idle, the next edge enters the hold state. In that state `hlda` is 1, `ctl_oe` and `ad_oe` are 0, `ale` stays driven at 0, `req_ready` is 0 and no transfer starts.
- R10: A `hold` raised during a transfer does not cut the transfer short. `hlda` stays 0 up to and including the cycle in which `done` is 1, and becomes 1 on the cycle after that.
- R11: When `hold` falls, `hlda` returns to 0 and `ctl_oe` to 1 on the next edge. A pending request is then accepted on the edge after that.
- R12: `done` is 1 for exactly one cycle: the cycle after the fourth state. With no wait states, that is the fifth cycle after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transfer request present |
| req_write | input | 1 | 1 for write, 0 for read |
| req_mem | input | 1 | 1 memory, 0 I/O |
| req_hi_en | input | 1 | Upper data byte enabled |
| req_seg | input | 2 | Segment code for status |
| req_ief | input | 1 | Interrupt-enable flag for status |
| req_addr | input | 20 | Transfer address |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Request can be accepted this edge |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rdata | output | 16 | Captured read data |
| ad_o | output | 16 | Shared address/data pins, driven value |
| ad_oe | output | 1 | Drive enable for shared address/data pins |
| ad_i | input | 16 | Shared address/data pins, sampled value |
| as_o | output | 4 | Top address / status pins |
| ale | output | 1 | Address latch strobe, always driven |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| mio | output | 1 | Memory (1) or I/O (0) |
| dtr | output | 1 | Transmit (1) or receive (0) |
| bhe_n | output | 1 | Upper byte enable, active low |
| ctl_oe | output | 1 | Drive enable for control and status pins |
| ready | input | 1 | Target ready; 0 inserts wait states |
| hold | input | 1 | Bus request from DMA master |
| hlda | output | 1 | Bus granted |

## Verification
Pin outputs decode the registered state, so each state's values appear one edge after the edge that enters it. The address state follows the accepting edge by one cycle. The strobes fall one cycle later, and the done pulse arrives on the fourth cycle after the address state plus one cycle for each wait. The bench drives inputs and samples outputs on the falling edge, and steps one falling edge per state. It sets `ready` before the edge that ends the second state or a wait state. It changes `ad_i` only after the third state's capture edge, so a late capture shows up in `rdata`. Hold checks count edges the same way: the grant is expected one edge after idle with `hold` high, and release one edge after `hold` falls.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  localparam int STAT_W = 4;
  localparam int SEG_W  = 2;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_TW   = 3'd3,
    ST_T3   = 3'd4,
    ST_T4   = 3'd5,
    ST_HOLD = 3'd6
  } tstate_e;

  function automatic logic [STAT_W-1:0] status_word(input logic ief, input logic [SEG_W-1:0] seg);
    return {1'b0, ief, seg};
  endfunction
endpackage

// File: rtl/mbus_tstate_fsm.sv
module mbus_tstate_fsm
  import mbus_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    req_valid,
  input  logic    hold,
  input  logic    ready,
  output tstate_e st,
  output logic    accept,
  output logic    can_take
);
  tstate_e st_nx;

  always_comb begin
    can_take = (st == ST_IDLE) && !hold;
    accept   = can_take && req_valid;
    st_nx    = st;
    case (st)
      ST_IDLE: begin
        if (hold)           st_nx = ST_HOLD;
        else if (req_valid) st_nx = ST_T1;
      end
      ST_T1:   st_nx = ST_T2;
      ST_T2:   st_nx = ready ? ST_T3 : ST_TW;
      ST_TW:   st_nx = ready ? ST_T3 : ST_TW;
      ST_T3:   st_nx = ST_T4;
      ST_T4:   st_nx = ST_IDLE;
      ST_HOLD: if (!hold) st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= st_nx;
  end
endmodule

// File: rtl/mbus_req_latch.sv
module mbus_req_latch
  import mbus_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int ADDR_W = DATA_W + STAT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  tstate_e           st,
  input  logic              req_write,
  input  logic              req_mem,
  input  logic              req_hi_en,
  input  logic [SEG_W-1:0]  req_seg,
  input  logic              req_ief,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] ad_i,
  output logic              lat_write,
  output logic              lat_mem,
  output logic              lat_hi,
  output logic [SEG_W-1:0]  lat_seg,
  output logic              lat_ief,
  output logic [ADDR_W-1:0] lat_addr,
  output logic [DATA_W-1:0] lat_wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              done
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lat_write <= 1'b0;
      lat_mem   <= 1'b0;
      lat_hi    <= 1'b0;
      lat_seg   <= '0;
      lat_ief   <= 1'b0;
      lat_addr  <= '0;
      lat_wdata <= '0;
      rdata     <= '0;
      done      <= 1'b0;
    end else begin
      if (accept) begin
        lat_write <= req_write;
        lat_mem   <= req_mem;
        lat_hi    <= req_hi_en;
        lat_seg   <= req_seg;
        lat_ief   <= req_ief;
        lat_addr  <= req_addr;
        lat_wdata <= req_wdata;
      end
      if (st == ST_T3 && !lat_write) rdata <= ad_i;
      done <= (st == ST_T4);
    end
  end
endmodule

// File: rtl/mbus_pin_drive.sv
module mbus_pin_drive
  import mbus_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int ADDR_W = DATA_W + STAT_W
) (
  input  tstate_e           st,
  input  logic              lat_write,
  input  logic              lat_mem,
  input  logic              lat_hi,
  input  logic [SEG_W-1:0]  lat_seg,
  input  logic              lat_ief,
  input  logic [ADDR_W-1:0] lat_addr,
  input  logic [DATA_W-1:0] lat_wdata,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe,
  output logic [STAT_W-1:0] as_o,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              mio,
  output logic              dtr,
  output logic              bhe_n,
  output logic              ctl_oe,
  output logic              hlda
);
  logic addr_ph, strobe_ph, data_ph;

  always_comb begin
    addr_ph   = (st == ST_T1);
    strobe_ph = (st == ST_T2) || (st == ST_TW) || (st == ST_T3);
    data_ph   = strobe_ph || (st == ST_T4);
    ale       = addr_ph;
    hlda      = (st == ST_HOLD);
    ctl_oe    = !hlda;
    ad_oe     = addr_ph || (lat_write && data_ph);
    ad_o      = addr_ph ? lat_addr[DATA_W-1:0] : lat_wdata;
    as_o      = addr_ph ? lat_addr[ADDR_W-1:DATA_W] : status_word(lat_ief, lat_seg);
    bhe_n     = addr_ph ? !lat_hi : 1'b1;
    rd_n      = !(strobe_ph && !lat_write);
    wr_n      = !(strobe_ph && lat_write);
    mio       = lat_mem;
    dtr       = lat_write;
  end
endmodule

// File: rtl/mbus_cycle_seq.sv
module mbus_cycle_seq
  import mbus_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int ADDR_W = DATA_W + STAT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_mem,
  input  logic              req_hi_en,
  input  logic [SEG_W-1:0]  req_seg,
  input  logic              req_ief,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe,
  input  logic [DATA_W-1:0] ad_i,
  output logic [STAT_W-1:0] as_o,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              mio,
  output logic              dtr,
  output logic              bhe_n,
  output logic              ctl_oe,
  input  logic              ready,
  input  logic              hold,
  output logic              hlda
);
  tstate_e           st;
  logic              accept;
  logic              lat_write, lat_mem, lat_hi, lat_ief;
  logic [SEG_W-1:0]  lat_seg;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] lat_wdata;

  mbus_tstate_fsm u_fsm (
    .clk(clk), .rst(rst), .req_valid(req_valid), .hold(hold), .ready(ready),
    .st(st), .accept(accept), .can_take(req_ready)
  );

  mbus_req_latch #(.DATA_W(DATA_W)) u_latch (
    .clk(clk), .rst(rst), .accept(accept), .st(st),
    .req_write(req_write), .req_mem(req_mem), .req_hi_en(req_hi_en),
    .req_seg(req_seg), .req_ief(req_ief), .req_addr(req_addr), .req_wdata(req_wdata),
    .ad_i(ad_i),
    .lat_write(lat_write), .lat_mem(lat_mem), .lat_hi(lat_hi), .lat_seg(lat_seg),
    .lat_ief(lat_ief), .lat_addr(lat_addr), .lat_wdata(lat_wdata),
    .rdata(rdata), .done(done)
  );

  mbus_pin_drive #(.DATA_W(DATA_W)) u_pins (
    .st(st), .lat_write(lat_write), .lat_mem(lat_mem), .lat_hi(lat_hi),
    .lat_seg(lat_seg), .lat_ief(lat_ief), .lat_addr(lat_addr), .lat_wdata(lat_wdata),
    .ad_o(ad_o), .ad_oe(ad_oe), .as_o(as_o), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
    .mio(mio), .dtr(dtr), .bhe_n(bhe_n), .ctl_oe(ctl_oe), .hlda(hlda)
  );
endmodule

// File: rtl/mbus_cycle_seq_chk.sv
module mbus_cycle_seq_chk
  import mbus_pkg::*;
(
  input logic    clk,
  input logic    rst,
  input tstate_e st,
  input logic    ale,
  input logic    rd_n,
  input logic    wr_n,
  input logic    dtr,
  input logic    hlda,
  input logic    hold,
  input logic    ctl_oe,
  input logic    ad_oe,
  input logic    done,
  input logic    ready
);
  assert_ale_no_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    ale |-> (rd_n && wr_n));
  assert_ale_single_R2: assert property (@(posedge clk) disable iff (rst)
    ale |=> !ale);
  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));
  assert_dtr_write_R7: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> dtr);
  assert_dtr_read_R5: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !dtr);
  assert_wait_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (st == ST_TW && !ready && !rd_n) |=> !rd_n);
  assert_hlda_float_R9: assert property (@(posedge clk) disable iff (rst)
    hlda |-> (!ctl_oe && !ad_oe && !ale));
  assert_hlda_needs_hold_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(hlda) |-> $past(hold));
  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_no_grant_mid_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> !hlda);
endmodule

bind mbus_cycle_seq mbus_cycle_seq_chk chk_i (
  .clk(clk), .rst(rst), .st(st), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .dtr(dtr),
  .hlda(hlda), .hold(hold), .ctl_oe(ctl_oe), .ad_oe(ad_oe), .done(done), .ready(ready)
);

// File: tb/mbus_cycle_seq_tb.sv
`timescale 1ns/1ps
module mbus_cycle_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_mem = 1'b0, req_hi_en = 1'b0, req_ief = 1'b0;
  logic [1:0]  req_seg = '0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, done, ad_oe, ale, rd_n, wr_n, mio, dtr, bhe_n, ctl_oe, hlda;
  logic [15:0] rdata, ad_o;
  logic [15:0] ad_i = '0;
  logic [3:0]  as_o;
  logic        ready = 1'b1, hold = 1'b0;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  mbus_cycle_seq dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write), .req_mem(req_mem),
    .req_hi_en(req_hi_en), .req_seg(req_seg), .req_ief(req_ief), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .done(done), .rdata(rdata),
    .ad_o(ad_o), .ad_oe(ad_oe), .ad_i(ad_i), .as_o(as_o), .ale(ale), .rd_n(rd_n),
    .wr_n(wr_n), .mio(mio), .dtr(dtr), .bhe_n(bhe_n), .ctl_oe(ctl_oe),
    .ready(ready), .hold(hold), .hlda(hlda)
  );

  // fields: write, mem, hi_en, seg[2], ief, waits[3], pad[2], addr[20], data[16]
  localparam int NV = 6;
  localparam logic [46:0] VEC [NV] = '{
    {1'b0, 1'b1, 1'b1, 2'b01, 1'b1, 3'd0, 2'b00, 20'hABCDE, 16'h1234},
    {1'b1, 1'b0, 1'b1, 2'b10, 1'b0, 3'd0, 2'b00, 20'h0_03F8, 16'h5AA5},
    {1'b0, 1'b1, 1'b0, 2'b11, 1'b0, 3'd2, 2'b00, 20'h7_0011, 16'hBEEF},
    {1'b1, 1'b1, 1'b1, 2'b00, 1'b1, 3'd3, 2'b00, 20'hF_FFF0, 16'hC3C3},
    {1'b0, 1'b0, 1'b0, 2'b10, 1'b1, 3'd1, 2'b00, 20'h0_0060, 16'h00FF},
    {1'b1, 1'b1, 1'b0, 2'b01, 1'b0, 3'd1, 2'b00, 20'h5_5555, 16'hFFFF}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic w, input logic m, input logic hi, input logic [1:0] sg,
                       input logic ie, input logic [19:0] a, input logic [15:0] d);
    while (!req_ready) @(negedge clk);
    req_write = w; req_mem = m; req_hi_en = hi; req_seg = sg; req_ief = ie;
    req_addr = a; req_wdata = d; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run_vec(input logic [46:0] v);
    logic w, m, hi, ie;
    logic [1:0]  sg;
    int          nw;
    logic [19:0] a;
    logic [15:0] d;
    w = v[46]; m = v[45]; hi = v[44]; sg = v[43:42]; ie = v[41]; nw = int'(v[40:38]);
    a = v[35:16]; d = v[15:0];
    ready = (nw == 0);
    issue(w, m, hi, sg, ie, a, d);
    // address state
    check("R2 ale in T1", ale, 1);
    check("R2 ad_o addr", ad_o, a[15:0]);
    check("R2 as_o addr", as_o, a[19:16]);
    check("R2 ad_oe T1", ad_oe, 1);
    check("R4 bhe_n T1", bhe_n, !hi);
    check("R7 mio", mio, m);
    check("R7 dtr", dtr, w);
    check("R2 no strobe T1", {rd_n, wr_n}, 2'b11);
    @(negedge clk);
    // second state
    check("R2 ale low T2", ale, 0);
    check("R3 status T2", as_o, {1'b0, ie, sg});
    check("R4 bhe_n after T1", bhe_n, 1);
    check("R5 rd_n T2", rd_n, w);
    check("R6 wr_n T2", wr_n, !w);
    check("R6 ad_oe T2", ad_oe, w);
    if (w) check("R6 wdata T2", ad_o, d);
    else ad_i = d;
    for (int i = 0; i < nw; i++) begin
      @(negedge clk);
      check("R8 strobe held in wait", {rd_n, wr_n}, w ? 2'b10 : 2'b01);
      check("R8 no done in wait", done, 0);
      check("R3 status wait", as_o, {1'b0, ie, sg});
      ready = (i == nw - 1);
    end
    @(negedge clk);
    // third state
    check("R8 strobe T3", {rd_n, wr_n}, w ? 2'b10 : 2'b01);
    check("R7 mio T3", mio, m);
    ready = 1'b1;
    @(negedge clk);
    // fourth state
    check("R8 strobe released T4", {rd_n, wr_n}, 2'b11);
    check("R12 no done T4", done, 0);
    check("R6 ad_oe T4", ad_oe, w);
    if (w) check("R6 wdata T4", ad_o, d);
    ad_i = ~d;
    @(negedge clk);
    check("R12 done", done, 1);
    if (!w) check("R5 rdata", rdata, d);
    @(negedge clk);
    check("R12 done single", done, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 rd_n", rd_n, 1);
    check("R1 wr_n", wr_n, 1);
    check("R1 ale", ale, 0);
    check("R1 hlda", hlda, 0);
    check("R1 done", done, 0);
    check("R1 ctl_oe", ctl_oe, 1);
    check("R1 req_ready", req_ready, 1);

    for (int k = 0; k < NV; k++) run_vec(VEC[k]);

    // R9 hold from idle, request pending
    hold = 1'b1;
    req_write = 1'b0; req_mem = 1'b1; req_hi_en = 1'b1; req_seg = 2'b10; req_ief = 1'b0;
    req_addr = 20'h3_4567; req_valid = 1'b1;
    @(negedge clk);
    check("R9 hlda", hlda, 1);
    check("R9 ctl_oe off", ctl_oe, 0);
    check("R9 ad_oe off", ad_oe, 0);
    check("R9 ale driven low", ale, 0);
    check("R9 req_ready low", req_ready, 0);
    @(negedge clk);
    check("R9 no cycle starts", ale, 0);
    // R11 release
    hold = 1'b0;
    @(negedge clk);
    check("R11 hlda released", hlda, 0);
    check("R11 ctl_oe back", ctl_oe, 1);
    check("R11 idle no ale", ale, 0);
    @(negedge clk);
    req_valid = 1'b0;
    check("R11 request accepted", ale, 1);
    check("R11 address out", ad_o, 16'h4567);
    repeat (4) @(negedge clk);
    check("R11 cycle completes", done, 1);

    // R10 hold raised mid-transfer
    @(negedge clk);
    issue(1'b1, 1'b1, 1'b1, 2'b00, 1'b0, 20'h1_2222, 16'h7777);
    hold = 1'b1;
    @(negedge clk);
    check("R10 hlda T2", hlda, 0);
    check("R10 strobe still runs", wr_n, 0);
    @(negedge clk);
    check("R10 hlda T3", hlda, 0);
    @(negedge clk);
    check("R10 hlda T4", hlda, 0);
    @(negedge clk);
    check("R10 done before grant", done, 1);
    check("R10 hlda at done", hlda, 0);
    @(negedge clk);
    check("R10 grant after done", hlda, 1);
    hold = 1'b0;
    @(negedge clk);
    check("R11 hlda drops", hlda, 0);

    // R1 reset mid-transfer
    issue(1'b0, 1'b1, 1'b0, 2'b01, 1'b1, 20'h0_1000, 16'h0);
    @(negedge clk);
    check("R1 pre-reset rd_n low", rd_n, 0);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid reset rd_n", rd_n, 1);
    check("R1 mid reset ale", ale, 0);
    check("R1 mid reset done", done, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 idle after reset", req_ready, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule